// File: doc/BRIEF.md
# Bridge ADC calibration sequencer

This block steers the calibration of a single-channel converter that reads a resistive bridge sensor, and it keeps the correction words that the calibration produces. A host writes a five-bit configuration word. One bit enables calibration mode. Two select bits choose the step. Two further bits choose which non-ratiometric offsets to measure. The block then takes digital conversion results from the front end, one per valid strobe, and works out the correction word for the chosen step.

The steps must run in a fixed order. The optional non-ratiometric offsets for the input path and the reference path come first. The ratiometric offset comes next. It uses a 4-bit coarse trim DAC, found by successive approximation, and then a fine 24-bit word taken from the residue that is left. Gain comes last. An active-low ready output rises while a step runs and falls when the step ends.

Outside calibration mode, each conversion result is corrected by adding the fine ratiometric offset word, with saturation.

Top module: `bridge_cal_seq`

## Requirements
- R1: After reset, the following are all zero: both non-ratiometric offset words, the fine offset word, the gain word, the trim DAC code, cal_mode, seq_err and corr_valid. ready_n is 1.
- R2: A write with cfg_data[4]=1, cfg_data[1:0]=00 and cfg_data[2] or cfg_data[3] set starts the non-ratiometric step. If bit 2 is set, the next conversion result is stored as the input-path offset. If bit 3 is set, the conversion after that (or the next one, when bit 2 is clear) is stored as the reference-path offset. Both words are kept in two's complement, unchanged from the raw result.
- R3: A non-ratiometric request after a completed ratiometric offset step is ignored: the stored offsets do not change and seq_err is set.
- R4: A write with cfg_data[4]=1 and cfg_data[1:0]=10 starts the ratiometric step. The trim DAC bits are tried from MSB to LSB, one conversion per bit. A trial bit is kept when the result is non-negative and cleared when the result is negative.
- R5: After the fourth trial, one more conversion gives the residue. The fine offset word becomes the negated residue, saturated to the 24-bit two's complement range, so a residue of 0x800000 gives 0x7FFFFF.
- R6: ready_n goes to 1 on the cycle after a step starts. It falls to 0 on the cycle after the conversion that ends the step.
- R7: A write with cfg_data[4]=1 and cfg_data[1:0]=01 runs the gain step only after a ratiometric offset step has completed. The gain word becomes the next conversion plus the fine word, saturated. A gain request made earlier is ignored and sets seq_err.
- R8: A write with both select bits at 1 starts no step, leaves ready_n and the trim code unchanged, and sets seq_err. seq_err stays set until reset.
- R9: When cal_mode is 0 and no step is running, each conversion result gives corr_valid one cycle later, with corr_data equal to the result plus the fine word, saturated. In calibration mode no corrected result is produced.
- R10: cal_mode is set by an accepted write with cfg_data[4]=1. It is cleared only by an accepted write with cfg_data[4]=0. Writes made while a step runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 5 | [4] enable, [3] reference NR, [2] input NR, [1:0] step select |
| conv_valid | input | 1 | Conversion result strobe |
| conv_data | input | 24 | Conversion result, two's complement |
| trim_dac | output | 4 | Coarse offset trim code to the front end |
| nr_in_off | output | 24 | Input-path non-ratiometric offset |
| nr_ref_off | output | 24 | Reference-path non-ratiometric offset |
| fine_off | output | 24 | Fine ratiometric offset word |
| gain_word | output | 24 | Gain calibration word |
| corr_data | output | 24 | Corrected conversion result |
| corr_valid | output | 1 | corr_data valid |
| ready_n | output | 1 | Active-low step-complete indication |
| cal_mode | output | 1 | Calibration mode active |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
The bench feeds the block from a front-end model whose result is an offset minus the trim code times a step size. With an offset of 5300 and a step of 1000, the search must settle on code 5. A design that kept bits on the wrong sign, or tried them in the wrong order, would settle on a different code. A residue at the most negative value must give 0x7FFFFF; a design that wraps instead would store 0x800000. The bench also sends requests out of order: a gain request before any offset step, a non-ratiometric request after the offset step, and a write with both select bits set. A design that acted on any of these would change a stored word or pulse ready_n. In calibration mode, a corrected result must not appear.

// File: rtl/bridge_cal_seq.sv
module bridge_cal_seq #(
  parameter int W  = 24,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [4:0]    cfg_data,
  input  logic          conv_valid,
  input  logic [W-1:0]  conv_data,
  output logic [DW-1:0] trim_dac,
  output logic [W-1:0]  nr_in_off,
  output logic [W-1:0]  nr_ref_off,
  output logic [W-1:0]  fine_off,
  output logic [W-1:0]  gain_word,
  output logic [W-1:0]  corr_data,
  output logic          corr_valid,
  output logic          ready_n,
  output logic          cal_mode,
  output logic          seq_err
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic signed [W:0] MAXV = (W+1)'((1 << (W-1)) - 1);
  localparam logic signed [W:0] MINV = -(W+1)'(1 << (W-1));

  typedef enum logic [2:0] {S_IDLE, S_NRIN, S_NRREF, S_SAR, S_FINE, S_GAIN} st_t;
  st_t st;
  logic [BW-1:0] idx;
  logic ref_pend, ratio_done;

  function automatic logic [W-1:0] sat(input logic signed [W:0] v);
    if (v > MAXV) return MAXV[W-1:0];
    if (v < MINV) return MINV[W-1:0];
    return v[W-1:0];
  endfunction

  wire signed [W:0] conv_x = $signed({conv_data[W-1], conv_data});
  wire signed [W:0] fine_x = $signed({fine_off[W-1], fine_off});
  wire [W-1:0] corr_sum = sat(conv_x + fine_x);
  wire [W-1:0] neg_res  = sat(-conv_x);
  wire busy = (st != S_IDLE);
  wire take = busy && conv_valid;
  wire [1:0] sel = cfg_data[1:0];
  wire cal_req = cfg_wr && !busy && cfg_data[4];
  wire bad_req = cal_req && ((sel == 2'b11) || (sel == 2'b01 && !ratio_done) ||
                 (sel == 2'b00 && ratio_done && (cfg_data[2] || cfg_data[3])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; ref_pend <= 1'b0; ratio_done <= 1'b0;
      trim_dac <= '0; nr_in_off <= '0; nr_ref_off <= '0; fine_off <= '0;
      gain_word <= '0; corr_data <= '0; corr_valid <= 1'b0;
      ready_n <= 1'b1; cal_mode <= 1'b0; seq_err <= 1'b0;
    end else begin
      corr_valid <= 1'b0;
      if (cfg_wr && !busy) cal_mode <= cfg_data[4];
      if (bad_req) seq_err <= 1'b1;
      else if (cal_req) begin
        case (sel)
          2'b10: begin
            st <= S_SAR; idx <= BW'(DW-1); ready_n <= 1'b1;
            trim_dac <= DW'(1) << (DW-1);
          end
          2'b01: begin st <= S_GAIN; ready_n <= 1'b1; end
          default: if (cfg_data[2] || cfg_data[3]) begin
            st <= cfg_data[2] ? S_NRIN : S_NRREF;
            ref_pend <= cfg_data[3];
            ready_n <= 1'b1;
          end
        endcase
      end
      if (!busy && !cal_mode && conv_valid) begin
        corr_valid <= 1'b1;
        corr_data  <= corr_sum;
      end
      if (take) begin
        case (st)
          S_NRIN: begin
            nr_in_off <= conv_data;
            if (ref_pend) st <= S_NRREF;
            else begin st <= S_IDLE; ready_n <= 1'b0; end
          end
          S_NRREF: begin
            nr_ref_off <= conv_data; ref_pend <= 1'b0;
            st <= S_IDLE; ready_n <= 1'b0;
          end
          S_SAR: begin
            trim_dac[idx] <= !conv_data[W-1];
            if (idx == '0) st <= S_FINE;
            else begin
              trim_dac[idx-1'b1] <= 1'b1;
              idx <= idx - 1'b1;
            end
          end
          S_FINE: begin
            fine_off <= neg_res; ratio_done <= 1'b1;
            st <= S_IDLE; ready_n <= 1'b0;
          end
          S_GAIN: begin
            gain_word <= corr_sum;
            st <= S_IDLE; ready_n <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r6_busy_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ready_n);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  a_r9_no_corr_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mode |=> !corr_valid);
  a_r3_nr_frozen_after_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_done |=> ($stable(nr_in_off) && $stable(nr_ref_off)));
  a_r10_cal_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode && !(cfg_wr && !cfg_data[4])) |=> cal_mode);
  a_r4_trim_stable_in_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAIN) |=> $stable(trim_dac));
endmodule

// File: tb/bridge_cal_seq_tb_top.sv
module bridge_cal_seq_tb_top;
  logic clk = 0, rst_n = 0, cfg_wr = 0, conv_valid = 0;
  logic [4:0] cfg_data = '0;
  logic [23:0] conv_data = '0;
  logic [3:0] trim_dac;
  logic [23:0] nr_in_off, nr_ref_off, fine_off, gain_word, corr_data;
  logic corr_valid, ready_n, cal_mode, seq_err;
  int checks = 0, fails = 0;
  longint fe_offset = 0;
  localparam longint STEP = 1000;

  always #10 clk = ~clk;

  bridge_cal_seq dut_i (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .conv_valid(conv_valid), .conv_data(conv_data), .trim_dac(trim_dac),
    .nr_in_off(nr_in_off), .nr_ref_off(nr_ref_off), .fine_off(fine_off),
    .gain_word(gain_word), .corr_data(corr_data), .corr_valid(corr_valid),
    .ready_n(ready_n), .cal_mode(cal_mode), .seq_err(seq_err));

  function automatic longint sat24(input longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction
  function automatic longint s24(input logic [23:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: mode 0 idle, 1 input NR, 2 ref NR, 3 search, 4 residue, 5 gain
  int m_mode; int m_bit; bit m_refp, m_rdone;
  longint m_dac, m_nin, m_nref, m_fine, m_gain, m_corr;
  bit m_cv, m_rdy, m_cal, m_err;
  always @(posedge clk) begin
    longint c;
    c = s24(conv_data);
    if (!rst_n) begin
      m_mode = 0; m_bit = 0; m_refp = 0; m_rdone = 0; m_dac = 0; m_nin = 0; m_nref = 0;
      m_fine = 0; m_gain = 0; m_corr = 0; m_cv = 0; m_rdy = 1; m_cal = 0; m_err = 0;
    end else begin
      m_cv = 0;
      if (m_mode == 0 && conv_valid && !m_cal) begin m_cv = 1; m_corr = sat24(c + m_fine); end
      if (m_mode != 0 && conv_valid) begin
        if (m_mode == 1) begin m_nin = c; if (m_refp) m_mode = 2; else begin m_mode = 0; m_rdy = 0; end end
        else if (m_mode == 2) begin m_nref = c; m_refp = 0; m_mode = 0; m_rdy = 0; end
        else if (m_mode == 3) begin
          if (c < 0) m_dac = m_dac - (longint'(1) << m_bit);
          if (m_bit == 0) m_mode = 4;
          else begin m_bit--; m_dac = m_dac + (longint'(1) << m_bit); end
        end
        else if (m_mode == 4) begin m_fine = sat24(-c); m_rdone = 1; m_mode = 0; m_rdy = 0; end
        else begin m_gain = sat24(c + m_fine); m_mode = 0; m_rdy = 0; end
      end else if (m_mode == 0 && cfg_wr) begin
        m_cal = cfg_data[4];
        if (cfg_data[4]) begin
          if (cfg_data[1:0] == 3) m_err = 1;
          else if (cfg_data[1:0] == 2) begin m_mode = 3; m_bit = 3; m_dac = 8; m_rdy = 1; end
          else if (cfg_data[1:0] == 1) begin
            if (!m_rdone) m_err = 1; else begin m_mode = 5; m_rdy = 1; end
          end else if (cfg_data[2] || cfg_data[3]) begin
            if (m_rdone) m_err = 1;
            else begin m_mode = cfg_data[2] ? 1 : 2; m_refp = cfg_data[3]; m_rdy = 1; end
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R4 model trim", trim_dac, m_dac);
    chk("R2 model nr_in", s24(nr_in_off), m_nin);
    chk("R2 model nr_ref", s24(nr_ref_off), m_nref);
    chk("R5 model fine", s24(fine_off), m_fine);
    chk("R7 model gain", s24(gain_word), m_gain);
    chk("R6 model ready_n", ready_n, m_rdy);
    chk("R10 model cal_mode", cal_mode, m_cal);
    chk("R8 model seq_err", seq_err, m_err);
    chk("R9 model corr_valid", corr_valid, m_cv);
    if (m_cv) chk("R9 model corr_data", s24(corr_data), m_corr);
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
  endtask
  task automatic wr(input logic [4:0] d);
    cfg_data = d; cfg_wr = 1; @(negedge clk); cfg_wr = 0; @(negedge clk);
  endtask
  task automatic conv(input longint v);
    conv_data = v[23:0]; conv_valid = 1; @(negedge clk); conv_valid = 0; @(negedge clk);
  endtask
  task automatic conv_fe();
    conv(sat24(fe_offset - longint'(trim_dac) * STEP));
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R1 reset ready_n", ready_n, 1);
    chk("R1 reset seq_err", seq_err, 0);
    chk("R1 reset trim", trim_dac, 0);
    chk("R1 reset fine", fine_off, 0);
    chk("R1 reset nr_in", nr_in_off, 0);
    wr(5'b10011);
    chk("R8 both selects err", seq_err, 1);
    chk("R8 both selects no ready", ready_n, 1);
    chk("R8 both selects trim", trim_dac, 0);
    do_reset();
    wr(5'b10001);
    chk("R7 early gain err", seq_err, 1);
    conv(4444);
    chk("R7 early gain ignored", gain_word, 0);
    do_reset();
    wr(5'b11100);
    chk("R6 ready rises", ready_n, 1);
    chk("R10 cal_mode set", cal_mode, 1);
    conv(-5);
    conv(1234);
    chk("R2 nr input", s24(nr_in_off), -5);
    chk("R2 nr ref", s24(nr_ref_off), 1234);
    chk("R6 ready falls", ready_n, 0);
    conv(99);
    chk("R9 no corr in cal", corr_valid, 0);
    fe_offset = 5300;
    wr(5'b10010);
    chk("R4 first trial", trim_dac, 8);
    for (int i = 0; i < 5; i++) begin conv_fe(); @(negedge clk); end
    chk("R4 search code", trim_dac, 5);
    chk("R5 fine word", s24(fine_off), -300);
    chk("R6 ratio done", ready_n, 0);
    chk("R8 no err so far", seq_err, 0);
    wr(5'b10100);
    conv(77);
    chk("R3 late nr err", seq_err, 1);
    chk("R3 nr kept", s24(nr_in_off), -5);
    wr(5'b10001);
    conv(500000);
    chk("R7 gain word", s24(gain_word), 499700);
    wr(5'b00000);
    chk("R10 cal_mode cleared", cal_mode, 0);
    conv_data = 24'd1000; conv_valid = 1; @(negedge clk); conv_valid = 0;
    chk("R9 corr valid", corr_valid, 1);
    chk("R9 corr data", s24(corr_data), 700);
    @(negedge clk);
    fe_offset = -8388608;
    wr(5'b10010);
    for (int i = 0; i < 5; i++) conv_fe();
    chk("R4 all bits cleared", trim_dac, 0);
    chk("R5 fine saturates", fine_off, 24'h7FFFFF);
    wr(5'b00000);
    conv_data = 24'd100; conv_valid = 1; @(negedge clk); conv_valid = 0;
    chk("R9 corr saturates", corr_data, 24'h7FFFFF);
    @(negedge clk);
    conv(-8388608);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule